// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block keeps the loop state of a 24-bit DSP-style instruction sequencer so that loop bodies run without any branch instructions. When the decoder starts a loop instruction, the block saves the enclosing loop context on an internal two-word system stack. It then loads a new loop-end address and iteration count and raises the loop flag. Each time the instruction at the loop-end address completes, it either sends the fetch unit back to the first body instruction or unwinds the context. Loops can be counted or endless. The end address is either absolute (taken from the second instruction word) or PC-relative. A conditional break and an explicit early termination are also handled.

The sequencer is a four-state machine. ENTER pushes the return-address/status frame and loads the new loop registers. EXIT_SR pops that frame and restores the two loop flags. EXIT_LA pops the saved end-address/count frame. IDLE is where instructions and loop-end events are accepted. The named transitions are:
- start (IDLE→ENTER, any loop-start class).
- resume (ENTER→IDLE).
- annul (ENTER→EXIT_SR when a counted loop starts with a zero count).
- break (IDLE→EXIT_SR on a conditional break whose condition is true).
- terminate (IDLE→EXIT_SR on the early-termination class).
- expire (IDLE→EXIT_SR when a counted loop's count reaches zero).
- unwind (EXIT_SR→EXIT_LA).
- done (EXIT_LA→IDLE).

While `busy` is high, strobes are not accepted.

Top module: `hwloop_ctrl`

## Requirements
- R1: A loop start (op_class 1 = counted absolute, 2 = counted relative, 3 = endless absolute, 4 = endless relative) first pushes {la, lc} and then pushes {op_pc+2, status word}. The stack pointer `stk_sp` rises by 2, and a later exit brings back the earlier la, lc, lf and fv.
- R2: An absolute start sets la to op_word2 masked to its low 16 bits. A relative start sets la to (op_pc + op_word2) modulo 2^24.
- R3: A counted start sets lf=1 and fv=0, even inside an endless loop. `sr_out` is `sr_in` with bit 15 replaced by lf and bit 14 replaced by fv.
- R4: An endless start sets lf=1 and fv=1 and leaves lc unchanged. A zero lc does not annul it.
- R5: A counted start with a zero count is annulled. la, lc, lf, fv and stk_sp return to their values before the start, and a single redirect to (new la)+1 follows.
- R6: When exec_valid reports that the instruction at la completed while lf=1, a counted loop decrements lc. If the result is non-zero, a one-cycle redirect to the loop's op_pc+2 is issued in the next cycle.
- R7: When that decrement reaches zero, the loop exits without a redirect. Only lf and fv are taken from the popped status word, and then la and lc are restored from the second pop.
- R8: With cnt_from_sp=1 the new lc is stk_sp+1 as it was before the start.
- R9: With cnt_from_sp=0 the new lc is the low 16 bits of cnt_operand.
- R10: A break (op_class 5) with cond_true=1 performs the exit and redirects to la+1, using la as it was before the exit. With cond_true=0 it changes nothing.
- R11: Early termination (op_class 6) performs the exit with no redirect.
- R12: While op_valid is high, op_cycles gives the cost of the class: 5 for classes 1, 2, 4 and 5; 4 for class 3; 1 for class 6.
- R13: The stack holds 16 frames. A push into a full stack sets the sticky flag stk_overflow and leaves stk_sp unchanged. A pop from an empty stack sets the sticky flag stk_underflow.
- R14: In an endless loop, every completion of the instruction at la redirects to the body start and leaves lc unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Loop-related instruction starts this cycle |
| op_class | input | 3 | 1/2 counted abs/rel, 3/4 endless abs/rel, 5 break, 6 terminate |
| op_pc | input | 24 | Address of the loop instruction |
| op_word2 | input | 24 | Second instruction word (end address or offset) |
| cnt_operand | input | 24 | Count value delivered by the datapath |
| cnt_from_sp | input | 1 | Count source is the stack pointer |
| cond_true | input | 1 | Evaluated break condition |
| exec_valid | input | 1 | An instruction completed this cycle |
| exec_pc | input | 24 | Address of the completed instruction |
| sr_in | input | 24 | Live status word from the datapath |
| busy | output | 1 | Push/pop sequence in progress |
| op_cycles | output | 3 | Cycle cost of the strobed class |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 24 | Redirect target |
| la | output | 24 | Current loop-end address |
| lc | output | 16 | Current loop count |
| lf | output | 1 | Loop active flag |
| fv | output | 1 | Endless loop flag |
| sr_out | output | 24 | Status word with loop flags merged in |
| stk_sp | output | 5 | Stack occupancy in words-pairs |
| stk_overflow | output | 1 | Sticky push-when-full |
| stk_underflow | output | 1 | Sticky pop-when-empty |

## Verification
The hardest situations to reach are the ones where the outer context must come back exactly. Examples are a counted loop inside an endless one (fv must return to 1 on exit) and an annulled loop inside a live counted loop (the restored la and lc must be the outer ones). The stimulus nests loop starts before it triggers the exits, and it gives the outer loops distinct non-zero counts and end addresses so that any mix-up in restoring them is visible. Stack overflow needs eight nested starts before a ninth. After that, nine terminations drain the stack and make the underflow visible on the last one.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic [2:0] {
        OPC_NONE    = 3'd0,
        OPC_DO_ABS  = 3'd1,
        OPC_DO_REL  = 3'd2,
        OPC_FOR_ABS = 3'd3,
        OPC_FOR_REL = 3'd4,
        OPC_BRK     = 3'd5,
        OPC_ENDDO   = 3'd6
    } opc_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ENTER   = 2'd1,
        ST_EXIT_SR = 2'd2,
        ST_EXIT_LA = 2'd3
    } state_e;

endpackage

// File: rtl/hwloop_count.sv
module hwloop_count #(
    parameter int PC_W = 24,
    parameter int LA_W = 16,
    parameter int LC_W = 16,
    parameter int SP_W = 5
) (
    input  logic            relative,
    input  logic [PC_W-1:0] op_pc,
    input  logic [PC_W-1:0] op_word2,
    input  logic [PC_W-1:0] cnt_operand,
    input  logic            cnt_from_sp,
    input  logic [SP_W-1:0] sp,
    output logic [PC_W-1:0] new_la,
    output logic [LC_W-1:0] new_lc,
    output logic [PC_W-1:0] ret_pc
);
    localparam logic [PC_W-1:0] LA_MASK = PC_W'((64'd1 << LA_W) - 64'd1);

    always_comb begin
        new_la = relative ? (op_pc + op_word2) : (op_word2 & LA_MASK);
        new_lc = cnt_from_sp ? (LC_W'(sp) + LC_W'(1)) : cnt_operand[LC_W-1:0];
        ret_pc = op_pc + PC_W'(2);
    end
endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack #(
    parameter int W     = 24,
    parameter int DEPTH = 16,
    parameter int SP_W  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [W-1:0]    push_w0,
    input  logic [W-1:0]    push_w1,
    output logic [W-1:0]    top_w0,
    output logic [W-1:0]    top_w1,
    output logic [SP_W-1:0] sp,
    output logic            ovf,
    output logic            udf
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [SP_W-1:0] FULL = SP_W'(DEPTH);

    logic [W-1:0] mem0 [DEPTH];
    logic [W-1:0] mem1 [DEPTH];
    logic         full, empty;
    logic [IDX_W-1:0] tidx;

    assign full  = (sp == FULL);
    assign empty = (sp == '0);
    assign tidx  = IDX_W'(sp - SP_W'(1));

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && sp == SP_W'(i)) begin
                mem0[i] <= push_w0;
                mem1[i] <= push_w1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp  <= '0;
            ovf <= 1'b0;
            udf <= 1'b0;
        end else if (push) begin
            if (full) ovf <= 1'b1;
            else      sp  <= sp + SP_W'(1);
        end else if (pop) begin
            if (empty) udf <= 1'b1;
            else       sp  <= sp - SP_W'(1);
        end
    end

    always_comb begin
        top_w0 = empty ? '0 : mem0[tidx];
        top_w1 = empty ? '0 : mem1[tidx];
    end

    AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (ovf && $stable(sp))); // R13
    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (udf && sp == '0)); // R13
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int LA_W   = 16,
    parameter int LC_W   = 16,
    parameter int DEPTH  = 16,
    parameter int LF_BIT = 15,
    parameter int FV_BIT = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_class,
    input  logic [23:0]     op_pc,
    input  logic [23:0]     op_word2,
    input  logic [23:0]     cnt_operand,
    input  logic            cnt_from_sp,
    input  logic            cond_true,
    input  logic            exec_valid,
    input  logic [23:0]     exec_pc,
    input  logic [23:0]     sr_in,
    output logic            busy,
    output logic [2:0]      op_cycles,
    output logic            redirect_valid,
    output logic [23:0]     redirect_pc,
    output logic [23:0]     la,
    output logic [15:0]     lc,
    output logic            lf,
    output logic            fv,
    output logic [23:0]     sr_out,
    output logic [4:0]      stk_sp,
    output logic            stk_overflow,
    output logic            stk_underflow
);
    localparam int SP_W = $clog2(DEPTH + 1);

    state_e          state_q, state_d;
    opc_e            opc;
    logic [PC_W-1:0] la_q, pend_la_q, pend_ret_q, redir_tgt_q, redir_pc_q;
    logic [LC_W-1:0] lc_q, pend_lc_q, lc_dec;
    logic            lf_q, fv_q, pend_for_q, redir_pend_q, redir_v_q;

    logic            op_take, is_start, is_rel, is_for, body_end, annul;
    logic [PC_W-1:0] new_la, ret_pc, st_w0, st_w1, top_w0, top_w1, sr_word;
    logic [LC_W-1:0] new_lc;
    logic            st_push, st_pop;
    logic [SP_W-1:0] sp;

    assign opc      = opc_e'(op_class);
    assign op_take  = (state_q == ST_IDLE) && op_valid && (opc != OPC_NONE);
    assign is_start = (opc == OPC_DO_ABS) || (opc == OPC_DO_REL) ||
                      (opc == OPC_FOR_ABS) || (opc == OPC_FOR_REL);
    assign is_rel   = (opc == OPC_DO_REL) || (opc == OPC_FOR_REL);
    assign is_for   = (opc == OPC_FOR_ABS) || (opc == OPC_FOR_REL);
    assign body_end = (state_q == ST_IDLE) && !op_take && exec_valid &&
                      lf_q && (exec_pc == la_q);
    assign lc_dec   = lc_q - LC_W'(1);
    assign annul    = !pend_for_q && (pend_lc_q == '0);

    hwloop_count #(.PC_W(PC_W), .LA_W(LA_W), .LC_W(LC_W), .SP_W(SP_W)) u_count (
        .relative    (is_rel),
        .op_pc       (op_pc),
        .op_word2    (op_word2),
        .cnt_operand (cnt_operand),
        .cnt_from_sp (cnt_from_sp),
        .sp          (sp),
        .new_la      (new_la),
        .new_lc      (new_lc),
        .ret_pc      (ret_pc)
    );

    hwloop_stack #(.W(PC_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (st_push),
        .pop     (st_pop),
        .push_w0 (st_w0),
        .push_w1 (st_w1),
        .top_w0  (top_w0),
        .top_w1  (top_w1),
        .sp      (sp),
        .ovf     (stk_overflow),
        .udf     (stk_underflow)
    );

    always_comb begin
        sr_word         = sr_in;
        sr_word[LF_BIT] = lf_q;
        sr_word[FV_BIT] = fv_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_take) begin
                    if (is_start)                                  state_d = ST_ENTER;
                    else if (opc == OPC_ENDDO)                     state_d = ST_EXIT_SR;
                    else if (opc == OPC_BRK && cond_true)          state_d = ST_EXIT_SR;
                end else if (body_end && !fv_q && lc_dec == '0) begin
                    state_d = ST_EXIT_SR;
                end
            end
            ST_ENTER:   state_d = annul ? ST_EXIT_SR : ST_IDLE;
            ST_EXIT_SR: state_d = ST_EXIT_LA;
            ST_EXIT_LA: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // stack control and cost outputs
    always_comb begin
        st_push = 1'b0;
        st_pop  = 1'b0;
        st_w0   = '0;
        st_w1   = '0;
        unique case (state_q)
            ST_IDLE: if (op_take && is_start) begin
                st_push = 1'b1;
                st_w0   = la_q;
                st_w1   = PC_W'(lc_q);
            end
            ST_ENTER: begin
                st_push = 1'b1;
                st_w0   = pend_ret_q;
                st_w1   = sr_word;
            end
            ST_EXIT_SR, ST_EXIT_LA: st_pop = 1'b1;
            default: ;
        endcase

        op_cycles = 3'd0;
        if (op_valid) begin
            unique case (opc)
                OPC_DO_ABS, OPC_DO_REL, OPC_FOR_REL, OPC_BRK: op_cycles = 3'd5;
                OPC_FOR_ABS:                                  op_cycles = 3'd4;
                OPC_ENDDO:                                    op_cycles = 3'd1;
                default:                                      op_cycles = 3'd0;
            endcase
        end
    end

    // state register and loop registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            la_q         <= '0;
            lc_q         <= '0;
            lf_q         <= 1'b0;
            fv_q         <= 1'b0;
            pend_la_q    <= '0;
            pend_lc_q    <= '0;
            pend_ret_q   <= '0;
            pend_for_q   <= 1'b0;
            redir_pend_q <= 1'b0;
            redir_tgt_q  <= '0;
            redir_v_q    <= 1'b0;
            redir_pc_q   <= '0;
        end else begin
            state_q   <= state_d;
            redir_v_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (op_take) begin
                        if (is_start) begin
                            pend_la_q    <= new_la;
                            pend_lc_q    <= new_lc;
                            pend_ret_q   <= ret_pc;
                            pend_for_q   <= is_for;
                            redir_pend_q <= 1'b0;
                        end else if (opc == OPC_BRK) begin
                            redir_pend_q <= 1'b1;
                            redir_tgt_q  <= la_q + PC_W'(1);
                        end else begin
                            redir_pend_q <= 1'b0;
                        end
                    end else if (body_end) begin
                        if (fv_q) begin
                            redir_v_q  <= 1'b1;
                            redir_pc_q <= top_w0;
                        end else begin
                            lc_q <= lc_dec;
                            if (lc_dec != '0) begin
                                redir_v_q  <= 1'b1;
                                redir_pc_q <= top_w0;
                            end else begin
                                redir_pend_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_ENTER: begin
                    la_q <= pend_la_q;
                    if (!pend_for_q) lc_q <= pend_lc_q;
                    lf_q <= 1'b1;
                    fv_q <= pend_for_q;
                    if (annul) begin
                        redir_pend_q <= 1'b1;
                        redir_tgt_q  <= pend_la_q + PC_W'(1);
                    end
                end
                ST_EXIT_SR: begin
                    lf_q <= top_w1[LF_BIT];
                    fv_q <= top_w1[FV_BIT];
                end
                ST_EXIT_LA: begin
                    la_q <= top_w0;
                    lc_q <= top_w1[LC_W-1:0];
                    if (redir_pend_q) begin
                        redir_v_q  <= 1'b1;
                        redir_pc_q <= redir_tgt_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy           = (state_q != ST_IDLE);
    assign redirect_valid = redir_v_q;
    assign redirect_pc    = redir_pc_q;
    assign la             = la_q;
    assign lc             = lc_q;
    assign lf             = lf_q;
    assign fv             = fv_q;
    assign sr_out         = sr_word;
    assign stk_sp         = sp;

    AST_ENTER_SETS_LF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |=> lf_q); // R3
    AST_FOREVER_KEEPS_LC: assert property (@(posedge clk) disable iff (!rst_n)
        (body_end && fv_q) |=> ($stable(lc_q) && redir_v_q)); // R14
    AST_CONTINUE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (body_end && !fv_q && lc_q != LC_W'(1)) |=> redir_v_q); // R6
    AST_EXIT_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXIT_LA) |=> (state_q == ST_IDLE)); // R7
    AST_NO_REDIRECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !redir_v_q); // R5
endmodule

// File: tb/hwloop_ctrl_bench.sv
module hwloop_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic [23:0] op_pc = '0, op_word2 = '0, cnt_operand = '0, exec_pc = '0, sr_in = '0;
    logic        cnt_from_sp = 1'b0, cond_true = 1'b0, exec_valid = 1'b0;
    logic        busy, redirect_valid, lf, fv, stk_overflow, stk_underflow;
    logic [2:0]  op_cycles;
    logic [23:0] redirect_pc, la, sr_out;
    logic [15:0] lc;
    logic [4:0]  stk_sp;

    int errors = 0;
    int checks = 0;
    logic [2:0]  cyc_seen;
    logic        rv, rv2;
    logic [23:0] rpc;

    always #10 clk = ~clk;

    hwloop_ctrl u_hwloop_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .op_pc(op_pc), .op_word2(op_word2), .cnt_operand(cnt_operand),
        .cnt_from_sp(cnt_from_sp), .cond_true(cond_true), .exec_valid(exec_valid),
        .exec_pc(exec_pc), .sr_in(sr_in), .busy(busy), .op_cycles(op_cycles),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .la(la), .lc(lc),
        .lf(lf), .fv(fv), .sr_out(sr_out), .stk_sp(stk_sp),
        .stk_overflow(stk_overflow), .stk_underflow(stk_underflow)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] cls, input logic [23:0] pc,
                          input logic [23:0] w2, input logic [23:0] cnt,
                          input logic src_sp, input logic cond);
        op_valid = 1'b1; op_class = cls; op_pc = pc; op_word2 = w2;
        cnt_operand = cnt; cnt_from_sp = src_sp; cond_true = cond;
        #1 cyc_seen = op_cycles;
        @(negedge clk);
        op_valid = 1'b0; op_class = 3'd0;
        while (busy) @(negedge clk);
        rv = redirect_valid;
        rpc = redirect_pc;
    endtask

    task automatic end_body(input logic [23:0] pc);
        exec_valid = 1'b1; exec_pc = pc;
        @(negedge clk);
        exec_valid = 1'b0;
        rv = redirect_valid;
        rpc = redirect_pc;
        while (busy) @(negedge clk);
        rv2 = redirect_valid;
    endtask

    task automatic t_reset();
        chk("R1", "reset sp", stk_sp, 0);
        chk("R3", "reset lf", lf, 0);
        chk("R4", "reset fv", fv, 0);
        chk("R2", "reset la", la, 0);
        chk("R13", "reset flags", {stk_overflow, stk_underflow}, 0);
    endtask

    task automatic t_counted_abs();
        run_op(3'd1, 24'h000100, 24'hAB0120, 24'd3, 1'b0, 1'b0);
        chk("R12", "counted abs cost", cyc_seen, 5);
        chk("R2", "abs la masked", la, 24'h000120);
        chk("R3", "lf/fv", {lf, fv}, 2'b10);
        chk("R3", "sr_out flags", sr_out[15:14], 2'b10);
        chk("R9", "lc", lc, 3);
        chk("R1", "sp after start", stk_sp, 2);
        end_body(24'h000120);
        chk("R6", "redirect 1", {rv, rpc}, {1'b1, 24'h000102});
        chk("R6", "lc after 1", lc, 2);
        end_body(24'h000120);
        chk("R6", "redirect 2", {rv, rpc}, {1'b1, 24'h000102});
        end_body(24'h000120);
        chk("R7", "no redirect on expire", {rv, rv2}, 2'b00);
        chk("R7", "restored la/lc", {la, 8'h0, lc}, 48'h0);
        chk("R7", "restored lf/fv/sp", {lf, fv, 3'b0, stk_sp}, 0);
    endtask

    task automatic t_nested_rel_break();
        run_op(3'd1, 24'h000010, 24'h000080, 24'd2, 1'b0, 1'b0);
        run_op(3'd2, 24'h000012, 24'h000020, 24'h120005, 1'b0, 1'b0);
        chk("R12", "counted rel cost", cyc_seen, 5);
        chk("R2", "rel la", la, 24'h000032);
        chk("R9", "count masked", lc, 16'h0005);
        chk("R1", "sp nested", stk_sp, 4);
        run_op(3'd6, 24'h000020, 24'h0, 24'h0, 1'b0, 1'b0);
        chk("R12", "terminate cost", cyc_seen, 1);
        chk("R11", "terminate no redirect", rv, 0);
        chk("R11", "outer restored", {la, lc}, {24'h000080, 16'd2});
        chk("R11", "outer flags sp", {lf, fv, stk_sp}, {2'b10, 5'd2});
        run_op(3'd5, 24'h000040, 24'h0, 24'h0, 1'b0, 1'b0);
        chk("R12", "break cost", cyc_seen, 5);
        chk("R10", "false break no effect", {rv, lf, stk_sp, la}, {1'b0, 1'b1, 5'd2, 24'h80});
        run_op(3'd5, 24'h000041, 24'h0, 24'h0, 1'b0, 1'b1);
        chk("R10", "true break redirect", {rv, rpc}, {1'b1, 24'h000081});
        chk("R10", "break unwound", {lf, stk_sp, la}, {1'b0, 5'd0, 24'h0});
    endtask

    task automatic t_forever();
        run_op(3'd1, 24'h000200, 24'h000300, 24'd7, 1'b0, 1'b0);
        run_op(3'd4, 24'hFFFFF0, 24'h000020, 24'd99, 1'b0, 1'b0);
        chk("R12", "endless rel cost", cyc_seen, 5);
        chk("R2", "rel la wraps", la, 24'h000010);
        chk("R4", "endless flags lc", {lf, fv, lc}, {2'b11, 16'd7});
        end_body(24'h000010);
        chk("R14", "endless redirect", {rv, rpc}, {1'b1, 24'hFFFFF2});
        chk("R14", "endless lc kept", lc, 7);
        end_body(24'h000010);
        chk("R14", "endless second pass", {rv, lc, stk_sp}, {1'b1, 16'd7, 5'd4});
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        chk("R7", "fv restored 0", {lf, fv, la}, {2'b10, 24'h300});
        run_op(3'd3, 24'h000204, 24'h000250, 24'h0, 1'b0, 1'b0);
        chk("R12", "endless abs cost", cyc_seen, 4);
        run_op(3'd1, 24'h000206, 24'h000240, 24'd2, 1'b0, 1'b0);
        chk("R3", "counted in endless clears fv", {lf, fv}, 2'b10);
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        chk("R7", "fv back to 1", {lf, fv, la}, {2'b11, 24'h250});
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        chk("R7", "fully unwound", {lf, fv, stk_sp}, 0);
    endtask

    task automatic t_annul_and_sp();
        run_op(3'd1, 24'h000400, 24'h000410, 24'd9, 1'b0, 1'b0);
        run_op(3'd1, 24'h000402, 24'h000408, 24'h010000, 1'b0, 1'b0);
        chk("R5", "annul redirect", {rv, rpc}, {1'b1, 24'h000409});
        chk("R5", "annul restores", {la, lc, lf, fv, stk_sp}, {24'h410, 16'd9, 2'b10, 5'd2});
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        run_op(3'd3, 24'h000500, 24'h000510, 24'h0, 1'b0, 1'b0);
        chk("R4", "endless zero lc not annulled", {rv, lf, fv, lc, stk_sp}, {3'b011, 16'd0, 5'd2});
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        run_op(3'd1, 24'h000600, 24'h000610, 24'hFFFFFF, 1'b1, 1'b0);
        chk("R8", "sp count at 0", lc, 1);
        run_op(3'd1, 24'h000602, 24'h000608, 24'h0, 1'b1, 1'b0);
        chk("R8", "sp count at 2", lc, 3);
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        chk("R1", "sp back to 0", stk_sp, 0);
    endtask

    task automatic t_stack_limits();
        for (int i = 0; i < 8; i++)
            run_op(3'd1, 24'h000700 + 24'(2 * i), 24'h000780, 24'd1, 1'b0, 1'b0);
        chk("R13", "full no overflow", {stk_sp, stk_overflow}, {5'd16, 1'b0});
        run_op(3'd1, 24'h000720, 24'h000790, 24'd1, 1'b0, 1'b0);
        chk("R13", "overflow sticky, sp held", {stk_sp, stk_overflow}, {5'd16, 1'b1});
        for (int i = 0; i < 8; i++)
            run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        chk("R13", "drained no underflow", {stk_sp, stk_underflow}, {5'd0, 1'b0});
        run_op(3'd6, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0);
        chk("R13", "underflow flag", {stk_underflow, stk_overflow}, 2'b11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counted_abs();
        t_nested_rel_break();
        t_forever();
        t_annul_and_sp();
        t_stack_limits();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule